// File: doc/BRIEF.md
# Counter overflow interrupt controller

This block sits beside a bank of event counters and turns their one-cycle overflow pulses into a single level-sensitive interrupt. Each of the 24 sources has a sticky status bit. A pulse sets the bit whether or not the source is enabled, and the bit holds until software clears it. A separate enable mask decides which latched bits reach the interrupt line. The line stays high as long as any bit is both latched and enabled.

Software changes the enable mask only through two write-only strobe registers, one that sets bits and one that clears bits. Because of this, no read-modify-write sequence is needed, and two agents cannot overwrite each other's changes. Latched status is cleared by writing ones to a dedicated clear register. The register port is 32 bits wide. Reads are combinational from the register address.

The source map is fixed. General-purpose counter k drives bit 8+k (bits 23:8). Bandwidth counter j drives bit j (bits 7:0). The counters themselves are outside this block.

Top module: `ovf_irq_ctrl`

## Requirements
- R1: A write to offset 0x00 (enable-set) sets every enable bit whose write-data bit is one. Enable bits written with zero keep their value.
- R2: A write to offset 0x04 (enable-clear) clears every enable bit whose write-data bit is one. Enable bits written with zero keep their value.
- R3: A read at offset 0x08 returns the current enable mask in bits 23:0.
- R4: A read at offset 0x10 returns the latched status in bits 23:0. General counter k occupies bit 8+k (k = 0..15) and bandwidth counter j occupies bit j (j = 0..7).
- R5: A one on `ovf_pulse[i]` at a clock edge sets status bit i from that edge onward, whether or not source i is enabled. The bit stays set until it is cleared.
- R6: A write to offset 0x0C (status-clear) clears every status bit whose write-data bit is one. Writing 0x00FFFFFF clears all 24 bits.
- R7: When a pulse on source i arrives in the same cycle as a status-clear write with bit i set, status bit i remains set.
- R8: `irq` is high exactly while at least one source has both its status bit and its enable bit set.
- R9: Reset clears every enable bit and every status bit. Bits 31:24 always read as zero. Write data bits 31:24 have no effect. Writes to the read-only offsets 0x08 and 0x10 change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_addr | input | 8 | Register byte offset for both reads and writes |
| reg_wr | input | 1 | Write strobe, one cycle per write |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr`, combinational |
| ovf_pulse | input | 24 | Overflow pulses; bits 23:8 general counters, bits 7:0 bandwidth counters |
| irq | output | 1 | Level interrupt, OR of status AND enable |

## Verification
The bench first targets a pulse that coincides with a clear of the same bit. A design that gives the clear priority would lose that overflow, and the status bit would read zero. It then latches a pulse on a disabled source and enables the source afterwards. A design that gates the latch with the enable would miss the interrupt here, and one that drives `irq` from raw status would raise it too early. Further checks write to the read-only offsets, set the upper data bits and clear the enable mask while status is still pending. These catch decode errors that corrupt state and an `irq` that fails to track the enable mask. Separate pulses on general counter 5 and on bandwidth counter 7 confirm that each source lands on its own status bit.

// File: rtl/ovf_irq_pkg.sv
package ovf_irq_pkg;
    localparam int unsigned GEN_CNT = 16;
    localparam int unsigned BW_CNT  = 8;

    localparam logic [7:0] OFS_EN_SET  = 8'h00;
    localparam logic [7:0] OFS_EN_CLR  = 8'h04;
    localparam logic [7:0] OFS_EN_STAT = 8'h08;
    localparam logic [7:0] OFS_ST_CLR  = 8'h0C;
    localparam logic [7:0] OFS_ST      = 8'h10;

    typedef struct packed {
        logic en_set;
        logic en_clr;
        logic st_clr;
    } wr_strb_t;
endpackage

// File: rtl/ovf_reg_decode.sv
module ovf_reg_decode
    import ovf_irq_pkg::*;
#(
    parameter int unsigned ADDR_W = 8,
    parameter int unsigned DATA_W = 32,
    parameter int unsigned N_SRC  = 24
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic              wr,
    input  logic [N_SRC-1:0]  en_q,
    input  logic [N_SRC-1:0]  st_q,
    output wr_strb_t          strb,
    output logic [DATA_W-1:0] rdata
);
    always_comb begin
        strb = '0;
        if (wr) begin
            strb.en_set = (addr == ADDR_W'(OFS_EN_SET));
            strb.en_clr = (addr == ADDR_W'(OFS_EN_CLR));
            strb.st_clr = (addr == ADDR_W'(OFS_ST_CLR));
        end
    end

    always_comb begin
        rdata = '0;
        if (addr == ADDR_W'(OFS_EN_STAT)) rdata[N_SRC-1:0] = en_q;
        else if (addr == ADDR_W'(OFS_ST)) rdata[N_SRC-1:0] = st_q;
    end
endmodule

// File: rtl/ovf_enable_mask.sv
module ovf_enable_mask #(
    parameter int unsigned N_SRC = 24
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             set_stb,
    input  logic             clr_stb,
    input  logic [N_SRC-1:0] wdata,
    output logic [N_SRC-1:0] en_q
);
    typedef struct packed {
        logic [N_SRC-1:0] mask;
    } en_state_t;

    en_state_t state_d, state_q;

    always_comb begin
        state_d = state_q;
        if (set_stb) state_d.mask = state_q.mask | wdata;
        if (clr_stb) state_d.mask = state_q.mask & ~wdata;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= '0;
        else        state_q <= state_d;
    end

    assign en_q = state_q.mask;

    // R1: bits written with one are enabled on the next cycle
    assert_set_bits_R1: assert property (@(posedge clk) disable iff (!rst_n)
        set_stb |=> ((en_q & $past(wdata)) == $past(wdata)));

    // R1/R2: bits written with zero keep their value
    assert_zero_bits_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (set_stb || clr_stb) |=> ((en_q & ~$past(wdata)) == ($past(en_q) & ~$past(wdata))));

    // R2: bits written with one are disabled on the next cycle
    assert_clr_bits_R2: assert property (@(posedge clk) disable iff (!rst_n)
        clr_stb |=> ((en_q & $past(wdata)) == '0));
endmodule

// File: rtl/ovf_status_latch.sv
module ovf_status_latch #(
    parameter int unsigned N_SRC = 24
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr_stb,
    input  logic [N_SRC-1:0] clr_bits,
    input  logic [N_SRC-1:0] pulse,
    output logic [N_SRC-1:0] st_q
);
    for (genvar i = 0; i < N_SRC; i++) begin : g_bit
        logic bit_d, bit_q;

        always_comb begin
            bit_d = bit_q;
            if (clr_stb && clr_bits[i]) bit_d = 1'b0;
            if (pulse[i])               bit_d = 1'b1;
        end

        always_ff @(posedge clk) begin
            if (!rst_n) bit_q <= 1'b0;
            else        bit_q <= bit_d;
        end

        assign st_q[i] = bit_q;

        // R5: a pulse latches the bit
        assert_pulse_sets_R5: assert property (@(posedge clk) disable iff (!rst_n)
            pulse[i] |=> bit_q);

        // R5: a latched bit stays set unless it is cleared
        assert_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
            (bit_q && !(clr_stb && clr_bits[i])) |=> bit_q);

        // R6: a clear without a pulse drops the bit
        assert_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
            (clr_stb && clr_bits[i] && !pulse[i]) |=> !bit_q);

        // R7: a pulse wins over a clear in the same cycle
        assert_pulse_wins_R7: assert property (@(posedge clk) disable iff (!rst_n)
            (clr_stb && clr_bits[i] && pulse[i]) |=> bit_q);
    end
endmodule

// File: rtl/ovf_irq_ctrl.sv
module ovf_irq_ctrl
    import ovf_irq_pkg::*;
#(
    parameter int unsigned N_GEN  = GEN_CNT,
    parameter int unsigned N_BW   = BW_CNT,
    parameter int unsigned ADDR_W = 8,
    parameter int unsigned DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic              reg_wr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic [N_GEN+N_BW-1:0] ovf_pulse,
    output logic              irq
);
    localparam int unsigned N_SRC = N_GEN + N_BW;

    wr_strb_t         strb;
    logic [N_SRC-1:0] en_q;
    logic [N_SRC-1:0] st_q;
    logic             unused_wdata_hi;

    assign unused_wdata_hi = ^reg_wdata[DATA_W-1:N_SRC];

    ovf_reg_decode #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .N_SRC(N_SRC)
    ) u_dec (
        .addr  (reg_addr),
        .wr    (reg_wr),
        .en_q  (en_q),
        .st_q  (st_q),
        .strb  (strb),
        .rdata (reg_rdata)
    );

    ovf_enable_mask #(.N_SRC(N_SRC)) u_en (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_stb (strb.en_set),
        .clr_stb (strb.en_clr),
        .wdata   (reg_wdata[N_SRC-1:0]),
        .en_q    (en_q)
    );

    ovf_status_latch #(.N_SRC(N_SRC)) u_st (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr_stb  (strb.st_clr),
        .clr_bits (reg_wdata[N_SRC-1:0]),
        .pulse    (ovf_pulse),
        .st_q     (st_q)
    );

    assign irq = |(st_q & en_q);

    // R8: an enabled pulse raises irq next cycle unless the enable was cleared
    assert_enabled_pulse_irq_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ((ovf_pulse & en_q) != '0 && !strb.en_clr) |=> irq);

    // R8: nothing enabled means no interrupt
    assert_no_enable_no_irq_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (en_q == '0) |-> !irq);

    // R3: enable readback follows the mask
    assert_en_readback_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_addr == ADDR_W'(OFS_EN_STAT)) |-> (reg_rdata[N_SRC-1:0] == en_q));

    // R9: writes to read-only offsets leave state unchanged
    assert_ro_write_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_wr && (reg_addr == ADDR_W'(OFS_EN_STAT) || reg_addr == ADDR_W'(OFS_ST))
         && ovf_pulse == '0) |=> ($stable(en_q) && $stable(st_q)));
endmodule

// File: tb/sim_ovf_irq_ctrl.sv
module sim_ovf_irq_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  reg_addr = '0;
    logic        reg_wr = 1'b0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [23:0] ovf_pulse = '0;
    logic        irq;

    int n_run = 0;
    int n_fail = 0;

    always #5 clk = ~clk;

    ovf_irq_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .ovf_pulse(ovf_pulse), .irq(irq)
    );

    typedef struct packed {
        logic [23:0] tag;
        logic        wr;
        logic [7:0]  addr;
        logic [31:0] data;
        logic [23:0] pulse;
        logic [31:0] exp_en;
        logic [31:0] exp_st;
        logic        exp_irq;
    } vec_t;

    localparam int NV = 13;
    localparam vec_t VECS [NV] = '{
        '{"R1 ", 1'b1, 8'h00, 32'h0000_0100, 24'h000000, 32'h0000_0100, 32'h0, 1'b0},
        '{"R8 ", 1'b0, 8'h00, 32'h0,         24'h000100, 32'h0000_0100, 32'h0000_0100, 1'b1},
        '{"R5 ", 1'b0, 8'h00, 32'h0,         24'h000001, 32'h0000_0100, 32'h0000_0101, 1'b1},
        '{"R6 ", 1'b1, 8'h0C, 32'h0000_0100, 24'h000000, 32'h0000_0100, 32'h0000_0001, 1'b0},
        '{"R1 ", 1'b1, 8'h00, 32'h0000_0001, 24'h000000, 32'h0000_0101, 32'h0000_0001, 1'b1},
        '{"R2 ", 1'b1, 8'h04, 32'h0000_0001, 24'h000000, 32'h0000_0100, 32'h0000_0001, 1'b0},
        '{"R7 ", 1'b1, 8'h0C, 32'h0000_0100, 24'h000100, 32'h0000_0100, 32'h0000_0101, 1'b1},
        '{"R9 ", 1'b1, 8'h00, 32'hFF80_0000, 24'h000000, 32'h0080_0100, 32'h0000_0101, 1'b1},
        '{"R4 ", 1'b0, 8'h00, 32'h0,         24'h800000, 32'h0080_0100, 32'h0080_0101, 1'b1},
        '{"R6 ", 1'b1, 8'h0C, 32'h00FF_FFFF, 24'h000000, 32'h0080_0100, 32'h0, 1'b0},
        '{"R9 ", 1'b1, 8'h08, 32'hFFFF_FFFF, 24'h000000, 32'h0080_0100, 32'h0, 1'b0},
        '{"R9 ", 1'b1, 8'h10, 32'hFFFF_FFFF, 24'h000000, 32'h0080_0100, 32'h0, 1'b0},
        '{"R2 ", 1'b1, 8'h04, 32'hFFFF_FFFF, 24'h000000, 32'h0, 32'h0, 1'b0}
    };

    task automatic check(input logic [23:0] tag, input logic [31:0] got, input logic [31:0] exp);
        n_run++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s got=%h exp=%h", tag, got, exp);
        end
    endtask

    task automatic step(input logic wr, input logic [7:0] addr, input logic [31:0] data,
                        input logic [23:0] pulse);
        @(negedge clk);
        reg_wr = wr; reg_addr = addr; reg_wdata = data; ovf_pulse = pulse;
        @(posedge clk);
        @(negedge clk);
        reg_wr = 1'b0; ovf_pulse = '0; reg_wdata = '0;
    endtask

    task automatic read(input logic [7:0] addr, output logic [31:0] val);
        reg_addr = addr;
        #1;
        val = reg_rdata;
    endtask

    task automatic check_all(input logic [23:0] tag, input logic [31:0] en,
                             input logic [31:0] st, input logic ir);
        logic [31:0] v;
        read(8'h08, v); check(tag, v, en);   // R3 readback
        read(8'h10, v); check(tag, v, st);   // R4 readback
        check(tag, {31'b0, irq}, {31'b0, ir});
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;
        // R9 reset state
        check_all("R9 ", 32'h0, 32'h0, 1'b0);

        for (int i = 0; i < NV; i++) begin
            step(VECS[i].wr, VECS[i].addr, VECS[i].data, VECS[i].pulse);
            check_all(VECS[i].tag, VECS[i].exp_en, VECS[i].exp_st, VECS[i].exp_irq);
        end

        // R4: general counter 5 -> bit 13, bandwidth counter 7 -> bit 7
        step(1'b0, 8'h00, 32'h0, 24'h1 << (8 + 5));
        check_all("R4 ", 32'h0, 32'h0000_2000, 1'b0);
        step(1'b0, 8'h00, 32'h0, 24'h000080);
        check_all("R4 ", 32'h0, 32'h0000_2080, 1'b0);
        // R8: enabling a source with pending status raises irq
        step(1'b1, 8'h00, 32'h0000_0080, 24'h0);
        check_all("R8 ", 32'h0000_0080, 32'h0000_2080, 1'b1);
        // R9: reset mid-run clears everything
        @(negedge clk) rst_n = 1'b0;
        @(posedge clk);
        @(negedge clk) rst_n = 1'b1;
        check_all("R9 ", 32'h0, 32'h0, 1'b0);

        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule